// File: doc/BRIEF.md
# Audio Codec Clock Enable Generator

This block turns two master clock inputs into the clock and clock enables that the internal sections of an audio codec run from. A glitch-free switch picks master clock A or master clock B as the system clock. The switch always releases the outgoing clock before the incoming clock is admitted. On the system clock, three down-counting dividers produce single-cycle enables: one for the hi-fi converters and DSP, one for the voice converter and PCM port, and one for the auxiliary measurement ADC. The dividers advance on every system clock cycle when the external source is chosen. When the PLL source is chosen, they advance only on cycles where the PLL tick input is high.

A single 16-bit control word, written through a plain address/data port on the bus clock, sets all of this. It holds the three ratio codes, the source choice, the master clock choice and two doubler enable flags. The doubler flags are passed straight out to the analog section. A ratio change is picked up when the divider next reloads, so the enable in progress is never cut short.

Top module: `clkdiv_top`

## Requirements
- R1: After reset the control word reads 0x0080: external source, all ratio codes zero, doublers off, and the system clock taken from master clock A.
- R2: The hi-fi enable fires once every N source ticks, where N is the 3-bit code in bits 14:12 plus one (1 to 8).
- R3: With the external source selected, the voice enable fires once every N source ticks, where N is the 4-bit code in bits 11:8 plus one (1 to 16).
- R4: With the PLL source selected, the voice enable fires on every source tick and the voice code has no effect.
- R5: The auxiliary enable period in source ticks follows the code in bits 5:3: codes 0 through 7 give 16, 12, 8, 6, 4, 3, 2 and 1.
- R6: Bit 7 picks the source: 1 means every system clock cycle is a tick, and 0 means only cycles with the PLL tick input high are ticks. No enable is ever high on a cycle that is not a tick.
- R7: Bits 15 and 6 always read as zero, and writing ones to them changes nothing.
- R8: The doubler outputs for clock A and clock B follow bits 1 and 2 of the control word, and they change only on a register write.
- R9: Bit 0 picks master clock B (1) or A (0). After a change the system clock runs at the new clock's period, the two clock gates are never open together, and no high or low phase of the system clock is shorter than the shorter input half-period.
- R10: A ratio change takes effect at the divider's next reload. Every enable interval around the change equals either the old or the new ratio.
- R11: A write to any address other than the control address leaves the word unchanged. A read from any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register port clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, sampled on busClk |
| addr | input | ADDR_W | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the address presented |
| clkA | input | 1 | Master clock A |
| clkB | input | 1 | Master clock B |
| pllTick | input | 1 | Tick qualifier from the PLL, synchronous to the system clock |
| sysClk | output | 1 | Selected, glitch-free system clock |
| hifiEn | output | 1 | Hi-fi path enable |
| voiceEn | output | 1 | Voice/PCM path enable |
| auxEn | output | 1 | Auxiliary ADC enable |
| dblA | output | 1 | Doubler enable for clock A |
| dblB | output | 1 | Doubler enable for clock B |

## Verification
A write lands on the next busClk rising edge, and a read is combinational, so read checks sample one bus cycle after the write strobe drops. The enables are combinational from the counter state and the current tick. The bench therefore samples them on the falling system clock edge, and it measures each interval in ticks counted on those same edges. A new ratio can need up to 16 ticks to flush the old count, and a clock change needs two edges of the outgoing clock plus two of the incoming one. For this reason the bench waits 50 system clock cycles before it arms its interval checks and 20 before it measures a period. Clock phase widths are timed against simulation time on every system clock transition for the whole run.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  localparam int CTRL_W   = 16;
  localparam int HIFI_W   = 3;
  localparam int VOICE_W  = 4;
  localparam int AUX_W    = 3;
  localparam int CNT_W    = 4;
  localparam int NUM_DIV  = 3;

  // bit positions decoded by the datapath and the clock switch
  localparam int HIFI_LSB  = 12;
  localparam int VOICE_LSB = 8;
  localparam int EXT_BIT   = 7;
  localparam int AUX_LSB   = 3;
  localparam int DBLB_BIT  = 2;
  localparam int DBLA_BIT  = 1;
  localparam int SELB_BIT  = 0;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0080;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 16'h7FBF;

  // settings handed from the control side to the dividers
  typedef struct packed {
    logic [HIFI_W-1:0]  hifiCode;
    logic [VOICE_W-1:0] voiceCode;
    logic [AUX_W-1:0]   auxCode;
    logic               useExt;
  } divCfg_t;

  // reload value (period minus one) of the auxiliary divider
  function automatic logic [CNT_W-1:0] auxReload(input logic [AUX_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = 4'd15;
      3'd1:    r = 4'd11;
      3'd2:    r = 4'd7;
      3'd3:    r = 4'd5;
      3'd4:    r = 4'd3;
      3'd5:    r = 4'd2;
      3'd6:    r = 4'd1;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  output divCfg_t           divCfg,
  output logic              selB,
  output logic              dblA,
  output logic              dblB
);

  logic [CTRL_W-1:0] ctrlReg;
  logic              addrHit;

  assign addrHit = (addr == CTRL_ADDR);

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
    end else if (wrEn && addrHit) begin
      ctrlReg <= wrData & CTRL_MASK;
    end
  end

  assign rdData = addrHit ? ctrlReg : '0;

  always_comb begin
    divCfg.hifiCode  = ctrlReg[HIFI_LSB +: HIFI_W];
    divCfg.voiceCode = ctrlReg[VOICE_LSB +: VOICE_W];
    divCfg.auxCode   = ctrlReg[AUX_LSB +: AUX_W];
    divCfg.useExt    = ctrlReg[EXT_BIT];
  end

  assign selB = ctrlReg[SELB_BIT];
  assign dblA = ctrlReg[DBLA_BIT];
  assign dblB = ctrlReg[DBLB_BIT];

endmodule

// File: rtl/clkdiv_clksw.sv
`timescale 1ns/1ps
module clkdiv_clksw (
  input  logic clkA,
  input  logic clkB,
  input  logic rstN,
  input  logic selB,
  output logic gateA,
  output logic gateB,
  output logic sysClk
);

  logic armA;
  logic armB;

  // path A: capture the request on the rising edge, open or close the gate on the falling edge
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) armA <= 1'b1;
    else       armA <= !selB && !gateB;
  end

  always_ff @(negedge clkA or negedge rstN) begin
    if (!rstN) gateA <= 1'b1;
    else       gateA <= armA;
  end

  // path B: same structure, waits for A to be released
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) armB <= 1'b0;
    else       armB <= selB && !gateA;
  end

  always_ff @(negedge clkB or negedge rstN) begin
    if (!rstN) gateB <= 1'b0;
    else       gateB <= armB;
  end

  assign sysClk = (clkA && gateA) || (clkB && gateB);

endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] reload,
  output logic         pulse
);

  logic [W-1:0] count;
  logic         atZero;

  assign atZero = (count == '0);
  assign pulse  = tick && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick) begin
      if (atZero) count <= reload;
      else        count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_datapath.sv
`timescale 1ns/1ps
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic    sysClk,
  input  logic    rstN,
  input  logic    pllTick,
  input  divCfg_t divCfg,
  output logic    srcTick,
  output logic    hifiEn,
  output logic    voiceEn,
  output logic    auxEn
);

  localparam int HIFI_IDX  = 0;
  localparam int VOICE_IDX = 1;
  localparam int AUX_IDX   = 2;

  logic [CNT_W-1:0]   reloadVal [NUM_DIV];
  logic [NUM_DIV-1:0] pulseVec;

  assign srcTick = divCfg.useExt || pllTick;

  always_comb begin
    reloadVal[HIFI_IDX]  = CNT_W'(divCfg.hifiCode);
    reloadVal[VOICE_IDX] = divCfg.useExt ? CNT_W'(divCfg.voiceCode) : '0;
    reloadVal[AUX_IDX]   = auxReload(divCfg.auxCode);
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    clkdiv_counter #(.W(CNT_W)) u_cnt (
      .clk    (sysClk),
      .rstN   (rstN),
      .tick   (srcTick),
      .reload (reloadVal[g]),
      .pulse  (pulseVec[g])
    );
  end

  assign hifiEn  = pulseVec[HIFI_IDX];
  assign voiceEn = pulseVec[VOICE_IDX];
  assign auxEn   = pulseVec[AUX_IDX];

endmodule

// File: rtl/clkdiv_top.sv
`timescale 1ns/1ps
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              clkA,
  input  logic              clkB,
  input  logic              pllTick,
  output logic              sysClk,
  output logic              hifiEn,
  output logic              voiceEn,
  output logic              auxEn,
  output logic              dblA,
  output logic              dblB
);

  divCfg_t divCfg;
  logic    selB;
  logic    gateA;
  logic    gateB;
  logic    srcTick;

  clkdiv_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .busClk (busClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .divCfg (divCfg),
    .selB   (selB),
    .dblA   (dblA),
    .dblB   (dblB)
  );

  clkdiv_clksw u_sw (
    .clkA   (clkA),
    .clkB   (clkB),
    .rstN   (rstN),
    .selB   (selB),
    .gateA  (gateA),
    .gateB  (gateB),
    .sysClk (sysClk)
  );

  clkdiv_datapath u_dp (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .pllTick (pllTick),
    .divCfg  (divCfg),
    .srcTick (srcTick),
    .hifiEn  (hifiEn),
    .voiceEn (voiceEn),
    .auxEn   (auxEn)
  );

endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk (
  input logic        busClk,
  input logic        sysClk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] rdData,
  input logic        dblA,
  input logic        dblB,
  input logic        hifiEn,
  input logic        voiceEn,
  input logic        auxEn,
  input logic        srcTick,
  input logic        gateA,
  input logic        gateB
);

  logic [4:0] hifiGap;
  logic [4:0] auxGap;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      hifiGap <= '0;
      auxGap  <= '0;
    end else if (srcTick) begin
      hifiGap <= hifiEn ? 5'd0 : (hifiGap == 5'd31 ? hifiGap : hifiGap + 5'd1);
      auxGap  <= auxEn  ? 5'd0 : (auxGap  == 5'd31 ? auxGap  : auxGap  + 5'd1);
    end
  end

  p_gate_excl_r9: assert property (@(posedge busClk) disable iff (!rstN)
    !(gateA && gateB));

  p_hifi_gap_r2: assert property (@(posedge sysClk) disable iff (!rstN)
    hifiEn |-> hifiGap <= 5'd7);

  p_aux_gap_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    auxEn |-> auxGap <= 5'd15);

  p_no_tick_hold_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    !srcTick |-> !(hifiEn || voiceEn || auxEn));

  p_reserved_zero_r7: assert property (@(posedge busClk) disable iff (!rstN)
    rdData[15] == 1'b0 && rdData[6] == 1'b0);

  p_dbl_hold_r8: assert property (@(posedge busClk) disable iff (!rstN)
    !wrEn |=> $stable(dblA) && $stable(dblB));

endmodule

bind clkdiv_top clkdiv_chk u_chk (
  .busClk  (busClk),
  .sysClk  (sysClk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdData  (rdData),
  .dblA    (dblA),
  .dblB    (dblB),
  .hifiEn  (hifiEn),
  .voiceEn (voiceEn),
  .auxEn   (auxEn),
  .srcTick (srcTick),
  .gateA   (gateA),
  .gateB   (gateB)
);

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;

  localparam logic [7:0] CTRL = 8'h10;

  logic        busClk = 1'b0;
  logic        clkA = 1'b0;
  logic        clkB = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = CTRL;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        pllTick = 1'b0;
  logic        sysClk, hifiEn, voiceEn, auxEn, dblA, dblB;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // divider monitor state, index 0 hifi, 1 voice, 2 aux
  int tickCnt [3];
  int pulses  [3];
  int bad     [3];
  int lastBad [3];
  int expA    [3];
  int expB    [3];
  int seenA   [3];
  int seenB   [3];
  int noTickPulse = 0;
  int runts = 0;
  int phase = 0;
  bit armed = 0;
  bit extMode = 1;
  logic       tk;
  logic [2:0] enVec;

  clkdiv_top #(.ADDR_W(8), .CTRL_ADDR(CTRL)) u0 (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .clkA(clkA), .clkB(clkB), .pllTick(pllTick),
    .sysClk(sysClk), .hifiEn(hifiEn), .voiceEn(voiceEn), .auxEn(auxEn),
    .dblA(dblA), .dblB(dblB)
  );

  initial forever #2 busClk = ~busClk;   // 250 MHz
  initial forever #5 clkA = ~clkA;       // 10 ns
  initial forever #7 clkB = ~clkB;       // 14 ns

  // interval monitor: samples on falling system clock edges, then drives the next PLL tick
  initial begin
    for (int i = 0; i < 3; i++) begin
      tickCnt[i] = 0; pulses[i] = 0; bad[i] = 0; lastBad[i] = 0;
      expA[i] = 1; expB[i] = 1; seenA[i] = 0; seenB[i] = 0;
    end
    forever begin
      @(negedge sysClk);
      tk = extMode || pllTick;
      enVec = {auxEn, voiceEn, hifiEn};
      if (armed && !tk && enVec != 3'b000) noTickPulse++;
      for (int i = 0; i < 3; i++) begin
        if (tk) begin
          tickCnt[i]++;
          if (enVec[i]) begin
            if (armed) begin
              pulses[i]++;
              if (tickCnt[i] == expA[i]) seenA[i]++;
              if (tickCnt[i] == expB[i]) seenB[i]++;
              if (tickCnt[i] != expA[i] && tickCnt[i] != expB[i]) begin
                bad[i]++;
                lastBad[i] = tickCnt[i];
              end
            end
            tickCnt[i] = 0;
          end
        end
      end
      phase++;
      pllTick = (phase % 3) != 0;
    end
  end

  // phase width monitor for runt pulses (R9)
  initial begin
    realtime last;
    last = 0.0;
    forever begin
      @(sysClk);
      if ($realtime > 20.0 && ($realtime - last) < 4.9) runts++;
      last = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge busClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0; addr = CTRL;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge busClk);
    addr = a;
    #1 d = rdData;
    addr = CTRL;
  endtask

  task automatic waitSys(input int n);
    repeat (n) @(negedge sysClk);
    #1;
  endtask

  task automatic measurePeriod(output realtime p);
    realtime t0;
    @(posedge sysClk); t0 = $realtime;
    @(posedge sysClk); p = $realtime - t0;
  endtask

  function automatic int auxExp(input int c);
    int base;
    if (c < 4) base = (c % 2) ? 12 : 16;
    else       base = (c % 2) ? 3 : 4;
    return base >> ((c >> 1) & 1);
  endfunction

  function automatic logic [15:0] cfgWord(input int h, input int v, input int a,
                                          input bit ext);
    return (16'(h) << 12) | (16'(v) << 8) | (16'(ext) << 7) | (16'(a) << 3);
  endfunction

  task automatic clearMon();
    for (int i = 0; i < 3; i++) begin
      pulses[i] = 0; bad[i] = 0; lastBad[i] = 0; seenA[i] = 0; seenB[i] = 0;
    end
    noTickPulse = 0;
  endtask

  task automatic runCfg(input int h, input int v, input int a, input bit ext);
    regWrite(CTRL, cfgWord(h, v, a, ext));
    extMode = ext;
    armed = 0;
    waitSys(50);
    clearMon();
    expA[0] = h + 1;              expB[0] = expA[0];
    expA[1] = ext ? v + 1 : 1;    expB[1] = expA[1];
    expA[2] = auxExp(a);          expB[2] = expA[2];
    armed = 1;
    waitSys(ext ? 70 : 110);
    armed = 0;
    // R2 hifi ratio, R6 when counted on PLL ticks
    check(bad[0] == 0 && pulses[0] >= 2, ext ? "R2 hifi period" : "R6 hifi period on PLL ticks",
          bad[0] ? lastBad[0] : pulses[0], expA[0]);
    // R3 voice ratio in external mode, R4 bypass in PLL mode
    check(bad[1] == 0 && pulses[1] >= 2, ext ? "R3 voice period" : "R4 voice bypass",
          bad[1] ? lastBad[1] : pulses[1], expA[1]);
    // R5 aux lookup
    check(bad[2] == 0 && pulses[2] >= 2, "R5 aux period",
          bad[2] ? lastBad[2] : pulses[2], expA[2]);
    if (!ext) check(noTickPulse == 0, "R6 enable without tick", noTickPulse, 0);
  endtask

  initial begin
    logic [15:0] rv;
    realtime per;

    repeat (20) @(negedge busClk);
    rstN = 1'b1;
    repeat (4) @(negedge busClk);

    // R1 reset state
    regRead(CTRL, rv);
    check(rv == 16'h0080, "R1 reset word", rv, 16'h0080);
    check(dblA == 1'b0 && dblB == 1'b0, "R1 doublers off", {dblB, dblA}, 0);
    waitSys(5);
    measurePeriod(per);
    check(per > 9.9 && per < 10.1, "R1 clock A selected", int'(per), 10);

    // external mode sweeps: all hifi, voice and aux codes
    for (int c = 0; c < 8; c++) runCfg(c, (2 * c + 1) % 16, c, 1'b1);
    for (int c = 0; c < 8; c++) runCfg(7 - c, 2 * c, 7 - c, 1'b1);

    // PLL mode: counting on qualified ticks, voice code ignored
    runCfg(2, 9, 0, 1'b0);
    runCfg(5, 15, 3, 1'b0);
    runCfg(0, 4, 6, 1'b0);
    runCfg(7, 1, 7, 1'b0);

    // R10 ratio change mid-count
    regWrite(CTRL, cfgWord(7, 0, 7, 1'b1));
    extMode = 1;
    waitSys(50);
    clearMon();
    expA[0] = 8; expB[0] = 2;
    armed = 1;
    waitSys(20);
    regWrite(CTRL, cfgWord(1, 0, 7, 1'b1));
    waitSys(40);
    armed = 0;
    check(bad[0] == 0, "R10 interval old or new", lastBad[0], 8);
    check(seenA[0] > 0 && seenB[0] > 0, "R10 new ratio applied", seenB[0], 1);

    // R7 reserved bits, R8 doublers, R9 switch to B
    regWrite(CTRL, 16'hFFFF);
    regRead(CTRL, rv);
    check(rv == 16'h7FBF, "R7 reserved bits", rv, 16'h7FBF);
    check(dblA == 1'b1 && dblB == 1'b1, "R8 doublers on", {dblB, dblA}, 3);
    waitSys(20);
    measurePeriod(per);
    check(per > 13.9 && per < 14.1, "R9 clock B period", int'(per), 14);

    // R11 address decode
    regWrite(8'h11, 16'h0000);
    regRead(CTRL, rv);
    check(rv == 16'h7FBF, "R11 foreign write ignored", rv, 16'h7FBF);
    regRead(8'h22, rv);
    check(rv == 16'h0000, "R11 foreign read zero", rv, 0);
    check(dblA == 1'b1 && dblB == 1'b1, "R8 doublers unchanged", {dblB, dblA}, 3);

    // back to A
    regWrite(CTRL, 16'h0082);
    check(dblA == 1'b1 && dblB == 1'b0, "R8 doubler A only", {dblB, dblA}, 1);
    waitSys(20);
    measurePeriod(per);
    check(per > 9.9 && per < 10.1, "R9 clock A period", int'(per), 10);
    regWrite(CTRL, 16'h0081);
    waitSys(20);
    regWrite(CTRL, 16'h0080);
    waitSys(20);
    check(runts == 0, "R9 no runt phase", runts, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule